// File: doc/BRIEF.md
# ADC Conversion Trigger Sequencer

This block decides when a multi-channel analog-to-digital converter begins a group of conversions. A group can be requested from three places: an external trigger pin, an internal timer event, and a software write. The two hardware sources are active-low levels. Each passes through a synchronizer and a low-level duration filter, so a glitch shorter than two clocks never starts a group. Each hardware source also has its own enable bit.

A start/busy flag records that a group is in flight. When the flag goes from 0 to 1, the block emits a one-clock start pulse to the conversion engine. In single mode, the end-of-group pulse from the engine clears the flag. In continuous mode the flag stays set: the engine keeps converting, and only a software stop ends the run. While the flag is set, every request is discarded.

The block also holds a converter power-enable bit. Reset clears it, and so does the halt input. The external trigger path ignores this bit. The internal timer path and the software start both require it.

Top module: `adc_trig_seq`

## Requirements
- R1: An accepted request sets `busy` and produces exactly one `grp_start` pulse, one clock wide, in the cycle in which `busy` rises.
- R2: In single mode (`cont` bit 0), an `eog` pulse while `busy` is set clears `busy` on the next clock.
- R3: In continuous mode (`cont` bit 1), `eog` does not clear `busy`. Later hardware triggers produce no further `grp_start` while the run lasts.
- R4: A hardware trigger counts only when its synchronized level has been low for at least two consecutive clocks. A one-clock low is ignored. A long low period is accepted at most once.
- R5: A request that arrives while `busy` is set is discarded. It causes no `grp_start` and is not remembered.
- R6: An enabled external trigger is accepted even when the power bit is 0. The internal trigger and `sw_start` are accepted only when the power bit is 1.
- R7: The power bit (`pwr_on`) is 0 after reset. A `halt` pulse clears it on the next clock, and `halt` overrides a write of 1 in the same cycle.
- R8: `sw_start` sets `busy` when idle and powered. `sw_stop` clears `busy` on the next clock and overrides any request in the same cycle.
- R9: A hardware trigger whose enable bit (`ext_en` or `int_en`) is 0 has no effect.
- R10: After reset, `busy`, `grp_start` and `pwr_on` are 0, and both hardware enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_trig_n | input | 1 | External trigger pin, active low, asynchronous |
| int_trig_n | input | 1 | Internal timer event, active low |
| cfg_we | input | 1 | Strobe that loads the four configuration bits |
| cfg_ext_en | input | 1 | External trigger enable value |
| cfg_int_en | input | 1 | Internal trigger enable value |
| cfg_cont | input | 1 | 1 selects continuous mode, 0 selects single mode |
| cfg_pwr | input | 1 | Power-enable value |
| sw_start | input | 1 | Software start strobe |
| sw_stop | input | 1 | Software clear of the busy flag |
| halt | input | 1 | Halt request; clears the power bit |
| eog | input | 1 | End-of-group pulse from the converter |
| grp_start | output | 1 | One-clock start-of-group pulse to the converter |
| busy | output | 1 | Start/busy flag |
| pwr_on | output | 1 | Power-enable bit |

## Verification
A filter counter stuck or off by one shows up at the ports within about four clocks of a trigger edge. Either a one-clock glitch starts a group, or a clean two-clock pulse does not. A busy flag that is not cleared in single mode shows up one group length after the start, when `busy` is still high after `eog`. A flag that does not hold in continuous mode shows up at the first `eog`, and from then on later triggers would wrongly produce `grp_start` pulses. Wrong priority between `sw_stop`, `halt` and the writes shows up on the very next clock, in `busy` or `pwr_on`.

// File: rtl/adc_trig_pkg.sv
// Package: shared constants and the configuration record for the ADC trigger sequencer.
// Assumes the hardware sources are indexed external first, internal second.
package adc_trig_pkg;

    localparam int NUM_HW_SRC = 2;
    localparam int SRC_EXT    = 0;
    localparam int SRC_INT    = 1;

    typedef struct packed {
        logic ext_en;
        logic int_en;
        logic cont;
        logic pwr;
    } trig_cfg_t;

    localparam trig_cfg_t CFG_RESET = '{ext_en: 1'b0, int_en: 1'b0, cont: 1'b0, pwr: 1'b0};

endpackage

// File: rtl/adc_trig_filter.sv
// Module: adc_trig_filter
// Brings an asynchronous active-low trigger level into the clock domain
// through SYNC_STAGES flops. It then counts consecutive low samples and
// raises `fire` for one clock when the count reaches LOW_MIN. The count
// saturates, so a long low period fires only once.
// Assumes SYNC_STAGES >= 2 and LOW_MIN >= 1.
module adc_trig_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int LOW_MIN     = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_n,
    output logic fire
);

    localparam int CW = $clog2(LOW_MIN + 1);
    localparam logic [CW-1:0] CNT_FIRE = CW'(LOW_MIN - 1);
    localparam logic [CW-1:0] CNT_SAT  = CW'(LOW_MIN);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          low_cnt;
    logic                   synced_n;

    // Synchronizer shift chain; idles high (no trigger).
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], trig_n};
    end

    assign synced_n = sync_q[SYNC_STAGES-1];

    // Count consecutive low samples, saturating at LOW_MIN.
    always_ff @(posedge clk) begin
        if (!rst_n)                 low_cnt <= '0;
        else if (synced_n)          low_cnt <= '0;
        else if (low_cnt != CNT_SAT) low_cnt <= low_cnt + 1'b1;
    end

    // Fire on the sample that completes the minimum low duration.
    assign fire = !synced_n && (low_cnt == CNT_FIRE);

    AST_FIRE_NEEDS_TWO_LOWS: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (!synced_n && !$past(synced_n))); // R4
    AST_FIRE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire); // R4

endmodule

// File: rtl/adc_trig_ctrl.sv
// Module: adc_trig_ctrl
// Holds the configuration bits and the start/busy flag. It combines the
// filtered hardware requests with software start/stop and issues the
// start-of-group pulse on every rising edge of busy.
// Assumes hw_fire pulses are one clock wide and already filtered.
module adc_trig_ctrl
    import adc_trig_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_HW_SRC-1:0] hw_fire,
    input  logic                  cfg_we,
    input  trig_cfg_t             cfg_in,
    input  logic                  sw_start,
    input  logic                  sw_stop,
    input  logic                  halt,
    input  logic                  eog,
    output logic                  busy,
    output logic                  grp_start,
    output logic                  pwr_on
);

    trig_cfg_t cfg_q;
    logic      busy_q;
    logic      busy_d;
    logic      grp_start_q;
    logic      req_ext;
    logic      req_int;
    logic      req_sw;
    logic      start_req;

    // Configuration register; halt forces power off over any write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
        end else begin
            if (cfg_we) cfg_q <= cfg_in;
            if (halt)   cfg_q.pwr <= 1'b0;
        end
    end

    // Request qualification per source; only the external path skips the power check.
    always_comb begin
        req_ext   = hw_fire[SRC_EXT] && cfg_q.ext_en;
        req_int   = hw_fire[SRC_INT] && cfg_q.int_en && cfg_q.pwr;
        req_sw    = sw_start && cfg_q.pwr;
        start_req = req_ext || req_int || req_sw;
    end

    // Next busy value: stop first, then start when idle, then single-mode end of group.
    always_comb begin
        busy_d = busy_q;
        if (sw_stop)                          busy_d = 1'b0;
        else if (!busy_q && start_req)        busy_d = 1'b1;
        else if (busy_q && eog && !cfg_q.cont) busy_d = 1'b0;
    end

    // Busy flag and the start pulse marking its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q      <= 1'b0;
            grp_start_q <= 1'b0;
        end else begin
            busy_q      <= busy_d;
            grp_start_q <= busy_d && !busy_q;
        end
    end

    assign busy      = busy_q;
    assign grp_start = grp_start_q;
    assign pwr_on    = cfg_q.pwr;

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        grp_start |=> !grp_start); // R1
    AST_START_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        grp_start |-> busy); // R1
    AST_SINGLE_END: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cfg_q.cont && eog && !cfg_we) |=> !busy); // R2
    AST_CONT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_q.cont && !sw_stop) |=> busy); // R3
    AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !sw_stop) |=> !grp_start); // R5
    AST_EXT_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_fire[SRC_EXT] && cfg_q.ext_en && !busy && !sw_stop) |=> (busy && grp_start)); // R6
    AST_HALT_PWR: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> !pwr_on); // R7
    AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        sw_stop |=> (!busy && !grp_start)); // R8

endmodule

// File: rtl/adc_trig_seq.sv
// Module: adc_trig_seq (top)
// ADC conversion trigger sequencer. It builds one glitch filter per hardware
// trigger source and feeds the filtered requests to the busy/config controller.
// Assumes the trigger inputs may be asynchronous; all else is in the clk domain.
module adc_trig_seq
    import adc_trig_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int LOW_MIN     = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_trig_n,
    input  logic int_trig_n,
    input  logic cfg_we,
    input  logic cfg_ext_en,
    input  logic cfg_int_en,
    input  logic cfg_cont,
    input  logic cfg_pwr,
    input  logic sw_start,
    input  logic sw_stop,
    input  logic halt,
    input  logic eog,
    output logic grp_start,
    output logic busy,
    output logic pwr_on
);

    logic [NUM_HW_SRC-1:0] trig_n_vec;
    logic [NUM_HW_SRC-1:0] hw_fire;
    trig_cfg_t             cfg_in;

    // Gather sources into a vector indexed by the package constants.
    always_comb begin
        trig_n_vec          = '1;
        trig_n_vec[SRC_EXT] = ext_trig_n;
        trig_n_vec[SRC_INT] = int_trig_n;
        cfg_in = '{ext_en: cfg_ext_en, int_en: cfg_int_en, cont: cfg_cont, pwr: cfg_pwr};
    end

    for (genvar s = 0; s < NUM_HW_SRC; s++) begin : g_filt
        adc_trig_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .LOW_MIN     (LOW_MIN)
        ) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .trig_n (trig_n_vec[s]),
            .fire   (hw_fire[s])
        );
    end

    adc_trig_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_fire   (hw_fire),
        .cfg_we    (cfg_we),
        .cfg_in    (cfg_in),
        .sw_start  (sw_start),
        .sw_stop   (sw_stop),
        .halt      (halt),
        .eog       (eog),
        .busy      (busy),
        .grp_start (grp_start),
        .pwr_on    (pwr_on)
    );

endmodule

// File: tb/sim_adc_trig_seq.sv
module sim_adc_trig_seq;

    localparam int GRP_CYC = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_trig_n = 1'b1, int_trig_n = 1'b1;
    logic cfg_we = 1'b0, cfg_ext_en = 1'b0, cfg_int_en = 1'b0, cfg_cont = 1'b0, cfg_pwr = 1'b0;
    logic sw_start = 1'b0, sw_stop = 1'b0, halt = 1'b0;
    logic eog;
    logic grp_start, busy, pwr_on;

    int n_chk = 0, n_bad = 0, n_start = 0, n_eog = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    adc_trig_seq u0 (
        .clk(clk), .rst_n(rst_n), .ext_trig_n(ext_trig_n), .int_trig_n(int_trig_n),
        .cfg_we(cfg_we), .cfg_ext_en(cfg_ext_en), .cfg_int_en(cfg_int_en),
        .cfg_cont(cfg_cont), .cfg_pwr(cfg_pwr), .sw_start(sw_start), .sw_stop(sw_stop),
        .halt(halt), .eog(eog), .grp_start(grp_start), .busy(busy), .pwr_on(pwr_on)
    );

    // Converter stub: GRP_CYC clocks after a start, and repeatedly while busy, pulse eog.
    int  stub_cnt;
    logic stub_run;
    always @(posedge clk) begin
        if (!rst_n) begin
            eog <= 1'b0; stub_cnt <= 0; stub_run <= 1'b0;
        end else begin
            eog <= 1'b0;
            if (grp_start) begin
                stub_run <= 1'b1; stub_cnt <= 0;
            end else if (!busy) begin
                stub_run <= 1'b0;
            end else if (stub_run) begin
                if (stub_cnt == GRP_CYC - 1) begin eog <= 1'b1; stub_cnt <= 0; end
                else stub_cnt <= stub_cnt + 1;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && grp_start) n_start++;
        if (rst_n && eog) n_eog++;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cfg(input bit e, input bit i, input bit c, input bit p);
        @(negedge clk);
        cfg_ext_en = e; cfg_int_en = i; cfg_cont = c; cfg_pwr = p; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse(input bit use_int, input int len);
        @(negedge clk);
        if (use_int) int_trig_n = 1'b0; else ext_trig_n = 1'b0;
        cyc(len);
        int_trig_n = 1'b1; ext_trig_n = 1'b1;
    endtask

    task automatic stop();
        @(negedge clk); sw_stop = 1'b1;
        @(negedge clk); sw_stop = 1'b0;
        cyc(2);
    endtask

    // Expected acceptance of a hardware pulse from an idle state (R4, R6, R9).
    function automatic bit exp_accept(input bit use_int, input int len, input bit e,
                                      input bit i, input bit p);
        if (len < 2) return 1'b0;
        if (use_int) return i && p;
        return e;
    endfunction

    initial begin
        int s0;
        void'($urandom(32'd4517));
        cyc(3);
        chk("R10 busy", busy, 0);
        chk("R10 grp_start", grp_start, 0);
        chk("R10 pwr_on", pwr_on, 0);
        rst_n = 1'b1;
        cyc(2);
        chk("R10 pwr_on after release", pwr_on, 0);
        // Enables are 0 after reset: triggers do nothing (R10, R9)
        pulse(0, 3); pulse(1, 3); cyc(6);
        chk("R10 R9 busy disabled", busy, 0);
        chk("R9 no start", n_start, 0);

        // R4 one-clock glitch ignored
        set_cfg(1, 0, 0, 0);
        pulse(0, 1); cyc(6);
        chk("R4 glitch busy", busy, 0);

        // R6 external works unpowered, R1 one start
        pulse(0, 2); cyc(4);
        chk("R6 ext unpowered busy", busy, 1);
        chk("R1 start count", n_start, 1);
        // R5 trigger while busy ignored
        pulse(0, 3); cyc(5);
        chk("R5 no extra start", n_start, 1);
        // R2 single mode ends at eog
        cyc(GRP_CYC + 5);
        chk("R2 busy cleared", busy, 0);
        chk("R5 not remembered", n_start, 1);

        // R6 internal needs power
        set_cfg(0, 1, 0, 0);
        pulse(1, 3); cyc(6);
        chk("R6 int unpowered", busy, 0);
        set_cfg(0, 1, 0, 1);
        pulse(1, 3); cyc(5);
        chk("R1 int powered busy", busy, 1);
        chk("R1 int start", n_start, 2);
        cyc(GRP_CYC + 5);
        chk("R2 int busy cleared", busy, 0);

        // R4 long low accepted only once
        set_cfg(1, 0, 0, 1);
        s0 = n_start;
        pulse(0, 3 * GRP_CYC); cyc(6);
        chk("R4 long low single start", n_start - s0, 1);
        chk("R4 long low idle after", busy, 0);

        // R3 continuous mode
        set_cfg(1, 0, 1, 1);
        s0 = n_eog;
        pulse(0, 2); cyc(5);
        chk("R3 cont busy", busy, 1);
        cyc(2 * GRP_CYC + 5);
        chk("R3 eog seen", (n_eog - s0) >= 2, 1);
        chk("R3 busy held", busy, 1);
        s0 = n_start;
        pulse(0, 3); cyc(6);
        chk("R3 trigger ignored", n_start - s0, 0);
        // R8 stop
        @(negedge clk); sw_stop = 1'b1;
        @(negedge clk); sw_stop = 1'b0;
        chk("R8 stop clears", busy, 0);

        // R8 software start, R6 needs power
        set_cfg(0, 0, 0, 0);
        @(negedge clk); sw_start = 1'b1; @(negedge clk); sw_start = 1'b0;
        chk("R6 sw unpowered", busy, 0);
        set_cfg(0, 0, 0, 1);
        s0 = n_start;
        @(negedge clk); sw_start = 1'b1; @(negedge clk); sw_start = 1'b0;
        chk("R8 sw start busy", busy, 1);
        @(negedge clk);
        chk("R1 sw start pulse", n_start - s0, 1);
        stop();
        @(negedge clk); sw_start = 1'b1; sw_stop = 1'b1;
        @(negedge clk); sw_start = 1'b0; sw_stop = 1'b0;
        chk("R8 stop wins", busy, 0);

        // R7 halt
        chk("R7 powered", pwr_on, 1);
        @(negedge clk); halt = 1'b1; @(negedge clk); halt = 1'b0;
        chk("R7 halt clears", pwr_on, 0);
        @(negedge clk); halt = 1'b1; cfg_pwr = 1'b1; cfg_we = 1'b1;
        @(negedge clk); halt = 1'b0; cfg_we = 1'b0;
        chk("R7 halt over write", pwr_on, 0);

        // Random single-mode pulses against the bench model
        for (int k = 0; k < 40; k++) begin
            bit e, i, p, u;
            int len;
            bit a;
            e = 1'($urandom); i = 1'($urandom); p = 1'($urandom); u = 1'($urandom);
            len = 1 + int'($urandom % 3);
            set_cfg(e, i, 0, p);
            s0 = n_start;
            pulse(u, len); cyc(5);
            a = exp_accept(u, len, e, i, p);
            chk("R4 R6 R9 random busy", busy, a);
            chk("R1 random starts", n_start - s0, a);
            stop();
        end

        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        end
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        end
        $finish;
    end

endmodule